// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the bus-facing state machine of a two-wire serial memory slave. It runs from a system clock that oversamples the bus. The serial clock and data lines pass through synchronizers and a glitch filter. The engine finds START and STOP conditions, decodes the device address byte and collects a two-byte word address. It acknowledges by pulling the data line low. Read bytes are shifted out most significant bit first.

The memory array and the self-timed programming logic sit outside the block. Read data comes in through a combinational read port that is addressed by the engine's address counter. Each received write byte is handed on as a strobe with its address and data. A commit pulse follows the STOP that closes a write. The array side raises a busy input while it programs, and the engine ignores its own address for that time. A bus master can therefore poll for completion.

Top module: `twowire_mem_slave`

## Requirements
- R1: A data fall while the clock line is high (START) aborts any transfer, in any state, and restarts device-address decoding. A data rise while the clock line is high (STOP) returns the engine to standby with the data line released.
- R2: The first byte after START is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal `chipSel`. Bit 0 selects read (1) or write (0). The acknowledge is a low level during the ninth clock. On a mismatch the engine stays silent until the next START.
- R3: While `wrBusy` is high, even a matching device address is not acknowledged.
- R4: After a write address, two address bytes follow. The low four bits of the first byte give address bits 11:8, and the second byte gives bits 7:0. Every address byte and data byte is acknowledged. Each data byte produces one `wrValid` pulse carrying its address and data.
- R5: Within a write, the low five address bits step by one after each data byte and wrap inside the 32-byte page. The upper bits stay fixed.
- R6: `wrCommit` pulses once on a STOP that ends a write carrying at least one data byte. An address-only write does not pulse it.
- R7: The address counter resets to 0 and holds the last accessed address plus one. A read started without a word address returns the byte at the counter and then increments it.
- R8: In a read, a master acknowledge after a byte requests the next byte. A master non-acknowledge releases the line, and after STOP the engine is idle. Sequential reads wrap from address 0xFFF to 0.
- R9: An address-only write, then a repeated START with a read address, reads from the address just written.
- R10: Bits are sampled on the clock rising edge. Output bits change only after a falling edge and go out most significant bit first.
- R11: A pulse on either bus line that lasts fewer than `FILT_LEN` system clocks after synchronization is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| chipSel | input | 3 | Strapped select bits compared with device address bits 3:1 |
| wrBusy | input | 1 | High while the array is programming |
| rdData | input | 8 | Array byte at `rdAddr` |
| sdaPullDown | output | 1 | High to pull the data line low |
| rdAddr | output | ADDR_W | Address counter, drives the array read port |
| wrValid | output | 1 | One-cycle strobe per received write byte |
| wrAddr | output | ADDR_W | Address of the write byte |
| wrData | output | 8 | Write byte |
| wrCommit | output | 1 | One-cycle pulse after a STOP that closes a write |

## Verification
On every cycle, the assertions check the following. The acknowledge drive stays inside the ninth-clock window and never overlaps the read-data drive. The engine drives nothing in standby. No acknowledge starts while the array reports busy. The address counter steps by one across the whole array on each read load and inside the page on each write. Only the bus scenarios can show the rest: the byte values that come back in a read, and the right address reaching the array after a dummy write or an aborted one. They also show that a filtered clock glitch leaves a byte unharmed, and that sequential reads wrap at the top of the array.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic setAddrHi;
    logic setAddrLo;
    logic wrStrobe;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/sms_datapath.sv
module sms_datapath
  import sms_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAGE_W   = 5,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         stb,
  input  logic [7:0]        rdData,
  output logic              sclF,
  output logic              sdaF,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] addrCnt
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

  logic [1:0] rawIn;
  logic [1:0] fOut;
  assign rawIn = {sclIn, sdaIn};

  // one synchronizer plus agreement filter per bus line
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC_LEN-1:0] syncQ;
    logic [FILT_LEN-1:0] histQ;
    logic                outQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        histQ <= '1;
        outQ  <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_LEN-2:0], rawIn[g]};
        histQ <= {histQ[FILT_LEN-2:0], syncQ[SYNC_LEN-1]};
        if (&histQ)       outQ <= 1'b1;
        else if (~|histQ) outQ <= 1'b0;
      end
    end
    assign fOut[g] = outQ;
  end
  assign sclF = fOut[1];
  assign sdaF = fOut[0];

  logic [7:0]      rxShift;
  logic [7:0]      txShift;
  logic [HI_W-1:0] hiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      hiQ     <= '0;
      addrCnt <= '0;
    end else begin
      if (stb.shiftIn)   rxShift <= {rxShift[6:0], sdaF};
      if (stb.setAddrHi) hiQ <= rxShift[HI_W-1:0];
      if (stb.setAddrLo) addrCnt <= {hiQ, rxShift};
      if (stb.wrStrobe)
        addrCnt <= {addrCnt[ADDR_W-1:PAGE_W], addrCnt[PAGE_W-1:0] + PAGE_ONE};
      if (stb.loadTx) begin
        txShift <= rdData;
        addrCnt <= addrCnt + ADDR_ONE;
      end
      if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];

  // R5
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStrobe |=> (addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W]))
                  && (addrCnt[PAGE_W-1:0] == $past(addrCnt[PAGE_W-1:0]) + PAGE_ONE));

  // R8
  read_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |=> addrCnt == $past(addrCnt) + ADDR_ONE);
endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
  import sms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [2:0] chipSel,
  input  logic       wrBusy,
  input  logic [7:0] rxByte,
  output dpStrobe_t  stb,
  output logic       ackDrive,
  output logic       txEn,
  output logic       wrCommit
);
  busState_t  state, nxtState;
  logic [3:0] bitCnt;
  logic       sclQ, sdaQ, masterAck, gotData;

  logic startEv, stopEv, sclRise, sclFall, devOk;
  assign startEv = sclQ & sclF & sdaQ & ~sdaF;
  assign stopEv  = sclQ & sclF & ~sdaQ & sdaF;
  assign sclRise = ~sclQ & sclF;
  assign sclFall = sclQ & ~sclF;
  assign devOk   = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == chipSel) && !wrBusy;

  always_comb begin
    stb = '0;
    if (!startEv && !stopEv && state != ST_IDLE) begin
      if (sclRise && state != ST_RDAT && bitCnt < 4'd8) stb.shiftIn = 1'b1;
      if (sclFall) begin
        if (state == ST_RDAT) begin
          if (bitCnt >= 4'd1 && bitCnt <= 4'd7) stb.shiftTx = 1'b1;
          if (bitCnt == 4'd9 && masterAck)      stb.loadTx  = 1'b1;
        end else begin
          if (bitCnt == 4'd8) begin
            case (state)
              ST_AHI:  stb.setAddrHi = 1'b1;
              ST_ALO:  stb.setAddrLo = 1'b1;
              ST_WDAT: stb.wrStrobe  = 1'b1;
              default: ;
            endcase
          end
          if (bitCnt == 4'd9 && nxtState == ST_RDAT) stb.loadTx = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      nxtState  <= ST_IDLE;
      bitCnt    <= '0;
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      masterAck <= 1'b0;
      gotData   <= 1'b0;
      ackDrive  <= 1'b0;
      txEn      <= 1'b0;
      wrCommit  <= 1'b0;
    end else begin
      sclQ     <= sclF;
      sdaQ     <= sdaF;
      wrCommit <= 1'b0;
      if (startEv) begin
        state    <= ST_DEV;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txEn     <= 1'b0;
        gotData  <= 1'b0;
      end else if (stopEv) begin
        wrCommit <= (state == ST_WDAT) && gotData;
        state    <= ST_IDLE;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txEn     <= 1'b0;
        gotData  <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise) begin
          if (state == ST_RDAT && bitCnt == 4'd8) masterAck <= ~sdaF;
          if (bitCnt < 4'd9) bitCnt <= bitCnt + 4'd1;
        end else if (sclFall) begin
          if (state == ST_RDAT) begin
            if (bitCnt == 4'd8) txEn <= 1'b0;
            if (bitCnt == 4'd9) begin
              bitCnt <= '0;
              if (masterAck) txEn <= 1'b1;
              else           state <= ST_IDLE;
            end
          end else begin
            if (bitCnt == 4'd8) begin
              case (state)
                ST_DEV: begin
                  if (devOk) begin
                    ackDrive <= 1'b1;
                    nxtState <= rxByte[0] ? ST_RDAT : ST_AHI;
                  end else begin
                    state  <= ST_IDLE;
                    bitCnt <= '0;
                  end
                end
                ST_AHI:  begin ackDrive <= 1'b1; nxtState <= ST_ALO;  end
                ST_ALO:  begin ackDrive <= 1'b1; nxtState <= ST_WDAT; end
                ST_WDAT: begin ackDrive <= 1'b1; nxtState <= ST_WDAT; gotData <= 1'b1; end
                default: ;
              endcase
            end
            if (bitCnt == 4'd9) begin
              ackDrive <= 1'b0;
              bitCnt   <= '0;
              state    <= nxtState;
              if (nxtState == ST_RDAT) txEn <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R2
  ack_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackDrive |-> bitCnt >= 4'd8);

  // R3
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackDrive) && state == ST_DEV) |-> !$past(wrBusy));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !ackDrive && !txEn);

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> state == ST_DEV && bitCnt == 4'd0);

  // R10
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrive && txEn));

  // R8
  rd_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDAT && bitCnt == 4'd9) |-> !txEn);

  // R6
  commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> $past(stopEv));
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
  import sms_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAGE_W   = 5,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        chipSel,
  input  logic              wrBusy,
  input  logic [7:0]        rdData,
  output logic              sdaPullDown,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit
);
  dpStrobe_t         stb;
  logic              sclF, sdaF, txBit, ackDrive, txEn;
  logic [7:0]        rxByte;
  logic [ADDR_W-1:0] addrCnt;

  sms_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .rdData(rdData), .sclF(sclF), .sdaF(sdaF), .rxByte(rxByte),
    .txBit(txBit), .addrCnt(addrCnt)
  );

  sms_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .chipSel(chipSel),
    .wrBusy(wrBusy), .rxByte(rxByte), .stb(stb), .ackDrive(ackDrive),
    .txEn(txEn), .wrCommit(wrCommit)
  );

  assign sdaPullDown = ackDrive | (txEn & ~txBit);
  assign rdAddr      = addrCnt;
  assign wrValid     = stb.wrStrobe;
  assign wrAddr      = addrCnt;
  assign wrData      = rxByte;
endmodule

// File: tb/twowire_mem_slave_tb_top.sv
module twowire_mem_slave_tb_top;
  localparam int DEPTH = 4096;
  localparam int HALF  = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic        sclM = 1'b1, sdaM = 1'b1;
  logic [2:0]  chipSel = 3'b101;
  logic        wrBusy = 1'b0;
  logic [7:0]  rdData;
  logic        sdaPullDown, wrValid, wrCommit, sdaLine;
  logic [11:0] rdAddr, wrAddr;
  logic [7:0]  wrData;

  assign sdaLine = sdaM & ~sdaPullDown;

  twowire_mem_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .chipSel(chipSel),
    .wrBusy(wrBusy), .rdData(rdData), .sdaPullDown(sdaPullDown), .rdAddr(rdAddr),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrCommit(wrCommit)
  );

  function automatic logic [7:0] patt(input int i);
    return 8'((i * 37) + (i >> 5));
  endfunction

  logic [7:0]  mem [DEPTH];
  logic [7:0]  model [DEPTH];
  logic [11:0] logA [64];
  logic [7:0]  logD [64];
  int          logN = 0;
  int          commitN = 0;

  assign rdData = mem[rdAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= patt(i);
    end else if (wrValid) begin
      mem[wrAddr]    <= wrData;
      logA[logN % 64] <= wrAddr;
      logD[logN % 64] <= wrData;
      logN           <= logN + 1;
    end
  end

  always @(posedge clk) if (wrCommit) commitN <= commitN + 1;

  int          nChk = 0, nFail = 0;
  logic [11:0] expPtr;
  logic [7:0]  wbuf [32];
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] devB(input logic [2:0] cs, input bit rw);
    return {4'b1010, cs, rw};
  endfunction

  task automatic busStart();
    sdaM = 1'b1; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b0; tick(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b1; tick(HALF);
  endtask

  task automatic sendBit(input bit b);
    sdaM = b;    tick(HALF);
    sclM = 1'b1; tick(HALF);
    sclM = 1'b0; tick(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; tick(HALF);
    sclM = 1'b1; tick(HALF / 2);
    ack = ~sdaLine;
    tick(HALF / 2);
    sclM = 1'b0; tick(2);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; tick(HALF);
      sclM = 1'b1; tick(HALF / 2);
      b[i] = sdaLine;
      tick(HALF / 2);
      sclM = 1'b0; tick(2);
    end
    sdaM = ~giveAck; tick(HALF);
    sclM = 1'b1;     tick(HALF);
    sclM = 1'b0;     tick(2);
    sdaM = 1'b1;
  endtask

  // write of n bytes from wbuf at address a; n == 0 is an address-only write
  task automatic doWrite(input logic [11:0] a, input int n);
    bit k0, k1, k2, kd;
    int base, cbase;
    logic [11:0] ea;
    base = logN; cbase = commitN;
    busStart();
    sendByte(devB(chipSel, 1'b0), k0);
    sendByte({4'h0, a[11:8]}, k1);
    sendByte(a[7:0], k2);
    check(k0 && k1 && k2, "R4 address bytes acked", {k0, k1, k2}, 3'b111);
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], kd);
      check(kd, "R4 data byte acked", kd, 1);
    end
    busStop();
    tick(4);
    check(logN - base == n, "R4 write strobe count", logN - base, n);
    for (int k = 0; k < n; k++) begin
      ea = {a[11:5], 5'(a[4:0] + 5'(k))};
      check(logA[(base + k) % 64] == ea, "R5 write address in page",
            logA[(base + k) % 64], ea);
      check(logD[(base + k) % 64] == wbuf[k], "R4 write data",
            logD[(base + k) % 64], wbuf[k]);
      model[ea] = wbuf[k];
    end
    check(commitN - cbase == ((n > 0) ? 1 : 0), "R6 commit pulses",
          commitN - cbase, (n > 0) ? 1 : 0);
    if (n > 0) expPtr = {a[11:5], 5'(a[4:0] + 5'(n))};
    else       expPtr = a;
  endtask

  // current-address read of n bytes, acking all but the last
  task automatic doRead(input int n, input string req);
    bit k0;
    logic [7:0] b;
    logic [11:0] ea;
    busStart();
    sendByte(devB(chipSel, 1'b1), k0);
    check(k0, "R2 read address acked", k0, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      ea = expPtr + 12'(k);
      check(b == model[ea], req, b, model[ea]);
    end
    busStop();
    check(sdaPullDown == 1'b0, "R8 line released after read", sdaPullDown, 0);
    expPtr = expPtr + 12'(n);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) model[i] = patt(i);
    rstN = 1'b0;
    tick(6);
    rstN = 1'b1;
    tick(4);
    expPtr = 12'h000;

    // R7 reset state
    check(rdAddr == 12'h000, "R7 counter resets to zero", rdAddr, 0);
    check(sdaPullDown == 1'b0 && wrValid == 1'b0, "R1 idle after reset",
          {sdaPullDown, wrValid}, 0);

    // R7 current-address read from reset value; R10 bit order
    doRead(2, "R10 read byte value and bit order");

    // R2 mismatched chip select and wrong type prefix are ignored
    begin
      bit a0, a1;
      int base;
      base = logN;
      busStart();
      sendByte(devB(chipSel ^ 3'b010, 1'b0), a0);
      sendByte(8'h00, a1);
      busStop();
      check(!a0 && !a1, "R2 chip select mismatch silent", {a0, a1}, 0);
      busStart();
      sendByte({4'b1011, chipSel, 1'b0}, a0);
      busStop();
      check(!a0, "R2 type prefix mismatch silent", a0, 0);
      check(logN == base, "R2 no write after mismatch", logN - base, 0);
    end

    // R3 busy blocks acknowledge; cleared busy acks again
    begin
      bit a0;
      wrBusy = 1'b1;
      busStart();
      sendByte(devB(chipSel, 1'b0), a0);
      busStop();
      check(!a0, "R3 nack while busy", a0, 0);
      wrBusy = 1'b0;
      busStart();
      sendByte(devB(chipSel, 1'b1), a0);
      check(a0, "R3 ack once idle", a0, 1);
      begin
        logic [7:0] b;
        recvByte(1'b0, b);
        check(b == model[expPtr], "R7 byte at counter", b, model[expPtr]);
      end
      busStop();
      expPtr = expPtr + 12'd1;
    end

    // R4 single byte write
    wbuf[0] = 8'h5C;
    doWrite(12'h3F0, 1);

    // R5 page rollover write, then R7 current-address read after it
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    doWrite(12'h7FE, 4);
    check(expPtr == 12'h7E2, "R5 counter stays in page", expPtr, 12'h7E2);
    doRead(1, "R7 read after page write");

    // R9 random read via address-only write
    doWrite(12'h7FE, 0);
    doRead(3, "R9 random read across page wrap data");

    // R8 sequential read wrapping at the top of the array
    doWrite(12'hFFE, 0);
    doRead(4, "R8 sequential wrap 0xFFF to 0");
    check(expPtr == 12'h002, "R8 counter after wrap", expPtr, 12'h002);

    // R1 START mid-byte aborts the word address
    begin
      bit a0;
      int base;
      logic [7:0] b;
      doWrite(12'h200, 0);
      base = logN;
      busStart();
      sendByte(devB(chipSel, 1'b0), a0);
      sendByte(8'h0A, a0);
      sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
      busStart();
      sendByte(devB(chipSel, 1'b1), a0);
      check(a0, "R1 restart decodes new address", a0, 1);
      recvByte(1'b0, b);
      busStop();
      check(b == model[12'h200], "R1 aborted address not applied", b, model[12'h200]);
      check(logN == base, "R1 no write from aborted frame", logN - base, 0);
      expPtr = 12'h201;
    end

    // R11 short clock glitch inside a data byte is ignored
    begin
      bit a0;
      int base;
      logic [7:0] v;
      v = 8'hA5;
      base = logN;
      busStart();
      sendByte(devB(chipSel, 1'b0), a0);
      sendByte(8'h05, a0);
      sendByte(8'h55, a0);
      for (int i = 7; i >= 0; i--) begin
        sendBit(v[i]);
        if (i == 4) begin
          sclM = 1'b1; tick(2);
          sclM = 1'b0; tick(3);
        end
      end
      sdaM = 1'b1; tick(HALF);
      sclM = 1'b1; tick(HALF / 2);
      a0 = ~sdaLine;
      tick(HALF / 2);
      sclM = 1'b0; tick(2);
      busStop();
      tick(4);
      check(a0 && logN - base == 1, "R11 glitch byte acked once", logN - base, 1);
      check(logD[base % 64] == 8'hA5 && logA[base % 64] == 12'h555,
            "R11 glitch byte intact", {logA[base % 64], logD[base % 64]}, {12'h555, 8'hA5});
      model[12'h555] = 8'hA5;
      expPtr = 12'h556;
    end

    // constrained random writes and reads
    for (int it = 0; it < 24; it++) begin
      logic [11:0] a;
      int n;
      a = 12'($urandom % DEPTH);
      if ($urandom % 2 == 0) begin
        n = 1 + int'($urandom % 6);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        doWrite(a, n);
      end else begin
        n = 1 + int'($urandom % 4);
        doWrite(a, 0);
        doRead(n, "R8 random sequential read data");
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog run hung actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule